// File: doc/BRIEF.md
# Seven-Channel Loopback and Terminal Interface Selector

This block steers data between the terminal side and the line side of seven line channels when the channels are configured from static control inputs. For every channel it captures terminal transmit data on a chosen edge of that channel's transmit clock, launches line receive data toward the terminal on a chosen edge of that channel's recovered receive clock, and can turn either path back on itself as a loopback. Line coding, pulse shaping and any register access lie outside the block.

All logic runs on one fast system clock. The transmit clocks, the recovered receive clocks and the master clock come in as level signals that the system clock samples, and their edges are found by comparing each sample with the one before. Any register update that an edge triggers shows at the outputs one system clock after the system clock sees that edge. A three-bit code chooses the looped channel, or all seven at once. An active-low enable and a type input choose between analog loopback and remote loopback. Analog loopback sends terminal transmit data back to the terminal receive outputs. Remote loopback sends line receive data back out to the line. A per-channel all-ones input replaces that channel's line transmit data with a continuous mark pattern, and the master clock sets its timing.

Top module: `loopback_selector`

## Requirements
- R1: While rst_ni is low, all four output vectors are zero, and they are still zero on the first clock after release.
- R2: On a channel that is not in all-ones or remote loopback, line_pos_o/line_neg_o take {term_pos_i, term_neg_i} when that channel's tclk_i edge is seen. The edge is a rise when tclk_rise_i=1 and a fall when tclk_rise_i=0.
- R3: On a channel that is not in analog loopback, term_pos_o/term_neg_o take {line_pos_i, line_neg_i} when that channel's rclk_i edge is seen. The edge is a rise when rclk_rise_i=1 and a fall when rclk_rise_i=0.
- R4: Loopback acts only while lb_en_ni=0. lb_sel_i=0 selects all channels, and lb_sel_i=k (1..7) selects channel bit k-1. Channels that are not selected, and every channel while lb_en_ni=1, behave as in R2/R3.
- R5: With lb_analog_i=1, a selected channel's term outputs take the R2 transmit word on its tclk edge and ignore line receive data. Its line outputs still follow R2.
- R6: With lb_analog_i=0, a selected channel's line outputs take {line_pos_i, line_neg_i} on its rclk edge and ignore terminal data. Its term outputs still follow R3.
- R7: With single_rail_i=1, term_neg_i is ignored and the transmit word is {term_pos_i, 0}. The receive word toward the terminal is {line_pos_i | line_neg_i, 0}, and term_neg_o is held low from the next clock on.
- R8: While all_ones_i[c]=1, channel c's line outputs change only on rising edges of mclk_i. Each such edge yields a mark on exactly one rail, alternating, and the first mark after the override starts is positive. tclk and remote loopback have no effect on them.
- R9: If no tclk, rclk or mclk edge occurs and single_rail_i is steady, all outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lb_en_ni | input | 1 | Loopback enable, active low |
| lb_analog_i | input | 1 | 1: analog loopback, 0: remote loopback |
| lb_sel_i | input | 3 | 0: all channels, k: channel k only |
| single_rail_i | input | 1 | 1: single-rail terminal data, 0: dual-rail |
| tclk_rise_i | input | 1 | Transmit sampling edge, 1 rising, 0 falling |
| rclk_rise_i | input | 1 | Receive launch edge, 1 rising, 0 falling |
| mclk_i | input | 1 | Master clock level for all-ones timing |
| all_ones_i | input | 7 | Per-channel all-ones override |
| tclk_i | input | 7 | Per-channel transmit clock levels |
| term_pos_i | input | 7 | Terminal transmit positive rail / data |
| term_neg_i | input | 7 | Terminal transmit negative rail |
| rclk_i | input | 7 | Per-channel recovered receive clock levels |
| line_pos_i | input | 7 | Line receive positive rail |
| line_neg_i | input | 7 | Line receive negative rail |
| line_pos_o | output | 7 | Line transmit positive rail |
| line_neg_o | output | 7 | Line transmit negative rail |
| term_pos_o | output | 7 | Terminal receive positive rail / data |
| term_neg_o | output | 7 | Terminal receive negative rail |

## Verification
The hardest state to reach is a channel whose all-ones override and remote loopback are both active, with its transmit and receive clocks toggling while the master clock is idle. Only in that state can a wrong priority show, because the line outputs must stay frozen even though edges arrive on other paths. To get there, the stimulus raises a random all-ones mask and enables remote loopback with selector code 0. It toggles every clock independently at random, so some cycles carry only transmit or receive edges. Each selector code is also visited in both loopback types, and the reference model checks that the channels left unselected are untouched.

// File: rtl/lbsel_pkg.sv
`timescale 1ns/1ps
package lbsel_pkg;

  typedef struct packed {
    logic pos;
    logic neg;
  } rail_t;

  // code 0 selects every channel, code k selects channel index k-1
  function automatic logic chan_hit(input logic [7:0] code, input int unsigned idx);
    return (code == 8'd0) || (code == 8'(idx + 1));
  endfunction

endpackage

// File: rtl/lbsel_edge.sv
`timescale 1ns/1ps
module lbsel_edge #(
  parameter int unsigned W = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] sig_i,
  input  logic         rise_i,
  output logic [W-1:0] edge_o
);

  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= sig_i;
  end

  always_comb begin
    if (rise_i) edge_o = sig_i & ~prev_q;
    else        edge_o = ~sig_i & prev_q;
  end

endmodule

// File: rtl/lbsel_decode.sv
`timescale 1ns/1ps
module lbsel_decode
  import lbsel_pkg::*;
#(
  parameter int unsigned N_CH  = 7,
  parameter int unsigned SEL_W = 3
) (
  input  logic             lb_en_ni,
  input  logic             lb_analog_i,
  input  logic [SEL_W-1:0] lb_sel_i,
  output logic [N_CH-1:0]  analog_o,
  output logic [N_CH-1:0]  remote_o
);

  logic [N_CH-1:0] hit;

  for (genvar c = 0; c < N_CH; c++) begin : g_hit
    assign hit[c] = chan_hit(8'(lb_sel_i), c);
  end

  always_comb begin
    analog_o = '0;
    remote_o = '0;
    if (!lb_en_ni) begin
      if (lb_analog_i) analog_o = hit;
      else             remote_o = hit;
    end
  end

endmodule

// File: rtl/lbsel_chan.sv
`timescale 1ns/1ps
module lbsel_chan
  import lbsel_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tx_edge_i,
  input  logic rx_edge_i,
  input  logic ones_edge_i,
  input  logic single_rail_i,
  input  logic analog_i,
  input  logic remote_i,
  input  logic all_ones_i,
  input  logic term_pos_i,
  input  logic term_neg_i,
  input  logic line_pos_i,
  input  logic line_neg_i,
  output logic line_pos_o,
  output logic line_neg_o,
  output logic term_pos_o,
  output logic term_neg_o
);

  rail_t tx_word, rx_word, line_raw;
  rail_t line_q, line_d, term_q, term_d;
  logic  ones_ph_q, ones_ph_d;

  always_comb begin
    tx_word.pos  = term_pos_i;
    tx_word.neg  = term_neg_i & ~single_rail_i;
    line_raw.pos = line_pos_i;
    line_raw.neg = line_neg_i;
    if (single_rail_i) begin
      rx_word.pos = line_pos_i | line_neg_i;
      rx_word.neg = 1'b0;
    end else begin
      rx_word = line_raw;
    end
  end

  // line side: all-ones beats remote loopback beats terminal data
  always_comb begin
    line_d    = line_q;
    ones_ph_d = ones_ph_q;
    if (all_ones_i) begin
      if (ones_edge_i) begin
        line_d.pos = ~ones_ph_q;
        line_d.neg = ones_ph_q;
        ones_ph_d  = ~ones_ph_q;
      end
    end else begin
      ones_ph_d = 1'b0;
      if (remote_i) begin
        if (rx_edge_i) line_d = line_raw;
      end else if (tx_edge_i) begin
        line_d = tx_word;
      end
    end
  end

  always_comb begin
    term_d = term_q;
    if (analog_i) begin
      if (tx_edge_i) term_d = tx_word;
    end else if (rx_edge_i) begin
      term_d = rx_word;
    end
    if (single_rail_i) term_d.neg = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q    <= '0;
      term_q    <= '0;
      ones_ph_q <= 1'b0;
    end else begin
      line_q    <= line_d;
      term_q    <= term_d;
      ones_ph_q <= ones_ph_d;
    end
  end

  assign line_pos_o = line_q.pos;
  assign line_neg_o = line_q.neg;
  assign term_pos_o = term_q.pos;
  assign term_neg_o = term_q.neg;

endmodule

// File: rtl/loopback_selector.sv
`timescale 1ns/1ps
module loopback_selector #(
  parameter int unsigned N_CH  = 7,
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lb_en_ni,
  input  logic             lb_analog_i,
  input  logic [SEL_W-1:0] lb_sel_i,
  input  logic             single_rail_i,
  input  logic             tclk_rise_i,
  input  logic             rclk_rise_i,
  input  logic             mclk_i,
  input  logic [N_CH-1:0]  all_ones_i,
  input  logic [N_CH-1:0]  tclk_i,
  input  logic [N_CH-1:0]  term_pos_i,
  input  logic [N_CH-1:0]  term_neg_i,
  input  logic [N_CH-1:0]  rclk_i,
  input  logic [N_CH-1:0]  line_pos_i,
  input  logic [N_CH-1:0]  line_neg_i,
  output logic [N_CH-1:0]  line_pos_o,
  output logic [N_CH-1:0]  line_neg_o,
  output logic [N_CH-1:0]  term_pos_o,
  output logic [N_CH-1:0]  term_neg_o
);

  localparam int unsigned MAX_CODE = (1 << SEL_W) - 1;

  initial begin
    if (N_CH > MAX_CODE) $error("selector too narrow for channel count");
  end

  logic [N_CH-1:0] tx_edge, rx_edge, analog, remote;
  logic [0:0]      ones_edge;

  lbsel_edge #(.W(N_CH)) i_tx_edge (
    .clk_i, .rst_ni, .sig_i(tclk_i), .rise_i(tclk_rise_i), .edge_o(tx_edge)
  );

  lbsel_edge #(.W(N_CH)) i_rx_edge (
    .clk_i, .rst_ni, .sig_i(rclk_i), .rise_i(rclk_rise_i), .edge_o(rx_edge)
  );

  lbsel_edge #(.W(1)) i_ones_edge (
    .clk_i, .rst_ni, .sig_i(mclk_i), .rise_i(1'b1), .edge_o(ones_edge)
  );

  lbsel_decode #(.N_CH(N_CH), .SEL_W(SEL_W)) i_decode (
    .lb_en_ni, .lb_analog_i, .lb_sel_i, .analog_o(analog), .remote_o(remote)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_chan
    lbsel_chan i_chan (
      .clk_i,
      .rst_ni,
      .tx_edge_i    (tx_edge[c]),
      .rx_edge_i    (rx_edge[c]),
      .ones_edge_i  (ones_edge[0]),
      .single_rail_i,
      .analog_i     (analog[c]),
      .remote_i     (remote[c]),
      .all_ones_i   (all_ones_i[c]),
      .term_pos_i   (term_pos_i[c]),
      .term_neg_i   (term_neg_i[c]),
      .line_pos_i   (line_pos_i[c]),
      .line_neg_i   (line_neg_i[c]),
      .line_pos_o   (line_pos_o[c]),
      .line_neg_o   (line_neg_o[c]),
      .term_pos_o   (term_pos_o[c]),
      .term_neg_o   (term_neg_o[c])
    );
  end

endmodule

// File: rtl/loopback_selector_chk.sv
`timescale 1ns/1ps
module loopback_selector_chk #(
  parameter int unsigned N_CH  = 7,
  parameter int unsigned SEL_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             lb_en_ni,
  input logic             lb_analog_i,
  input logic [SEL_W-1:0] lb_sel_i,
  input logic             single_rail_i,
  input logic             tclk_rise_i,
  input logic             rclk_rise_i,
  input logic             mclk_i,
  input logic [N_CH-1:0]  all_ones_i,
  input logic [N_CH-1:0]  tclk_i,
  input logic [N_CH-1:0]  term_pos_i,
  input logic [N_CH-1:0]  term_neg_i,
  input logic [N_CH-1:0]  rclk_i,
  input logic [N_CH-1:0]  line_pos_i,
  input logic [N_CH-1:0]  line_neg_i,
  input logic [N_CH-1:0]  line_pos_o,
  input logic [N_CH-1:0]  line_neg_o,
  input logic [N_CH-1:0]  term_pos_o,
  input logic [N_CH-1:0]  term_neg_o
);

  assert_reset_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(rst_ni) |-> (line_pos_o == '0 && line_neg_o == '0 &&
                        term_pos_o == '0 && term_neg_o == '0));

  assert_single_neg_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(single_rail_i) |-> term_neg_o == '0);

  assert_hold_no_edge_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $stable(tclk_i) && $stable(rclk_i) && $stable(mclk_i) &&
     $stable(single_rail_i))
    |=> ($stable(line_pos_o) && $stable(line_neg_o) &&
         $stable(term_pos_o) && $stable(term_neg_o)));

  for (genvar c = 0; c < N_CH; c++) begin : g_ones
    assert_ones_one_rail_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(rst_ni) && $rose(mclk_i) && all_ones_i[c])
      |=> (line_pos_o[c] ^ line_neg_o[c]));

    assert_ones_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(rst_ni) && !$rose(mclk_i) && all_ones_i[c])
      |=> ($stable(line_pos_o[c]) && $stable(line_neg_o[c])));
  end

endmodule

bind loopback_selector loopback_selector_chk #(.N_CH(N_CH), .SEL_W(SEL_W)) i_chk (.*);

// File: tb/test_loopback_selector.sv
`timescale 1ns/1ps
module test_loopback_selector;

  localparam int N = 7;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic lb_en_ni = 1'b1, lb_analog_i = 1'b0, single_rail_i = 1'b0;
  logic tclk_rise_i = 1'b1, rclk_rise_i = 1'b1, mclk_i = 1'b0;
  logic [2:0] lb_sel_i = '0;
  logic [N-1:0] all_ones_i = '0, tclk_i = '0, rclk_i = '0;
  logic [N-1:0] term_pos_i = '0, term_neg_i = '0, line_pos_i = '0, line_neg_i = '0;
  logic [N-1:0] line_pos_o, line_neg_o, term_pos_o, term_neg_o;

  always #2.5 clk = ~clk;

  loopback_selector i_loopback_selector (
    .clk_i(clk), .rst_ni, .lb_en_ni, .lb_analog_i, .lb_sel_i, .single_rail_i,
    .tclk_rise_i, .rclk_rise_i, .mclk_i, .all_ones_i, .tclk_i, .term_pos_i,
    .term_neg_i, .rclk_i, .line_pos_i, .line_neg_i, .line_pos_o, .line_neg_o,
    .term_pos_o, .term_neg_o
  );

  int checks = 0, fails = 0;
  bit done = 0, comparing = 0;
  string tag = "R1";
  bit tog_t = 1, tog_r = 1, tog_m = 0;

  // behavioural reference, one entry per channel
  bit m_lp[N], m_ln[N], m_tp[N], m_tn[N], m_ph[N];
  bit p_t[N], p_r[N], p_m;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int c = 0; c < N; c++) begin
        m_lp[c] = 0; m_ln[c] = 0; m_tp[c] = 0; m_tn[c] = 0; m_ph[c] = 0;
        p_t[c] = 0; p_r[c] = 0;
      end
      p_m = 0;
    end else begin
      bit me;
      me = mclk_i && !p_m;
      for (int c = 0; c < N; c++) begin
        bit te, re, sel, ana, rem, txp, txn;
        te  = tclk_rise_i ? (tclk_i[c] && !p_t[c]) : (!tclk_i[c] && p_t[c]);
        re  = rclk_rise_i ? (rclk_i[c] && !p_r[c]) : (!rclk_i[c] && p_r[c]);
        sel = (lb_sel_i == 0) || (int'(lb_sel_i) == c + 1);
        ana = !lb_en_ni && lb_analog_i && sel;
        rem = !lb_en_ni && !lb_analog_i && sel;
        txp = term_pos_i[c];
        txn = single_rail_i ? 1'b0 : term_neg_i[c];
        if (all_ones_i[c]) begin
          if (me) begin
            m_lp[c] = !m_ph[c]; m_ln[c] = m_ph[c]; m_ph[c] = !m_ph[c];
          end
        end else begin
          m_ph[c] = 0;
          if (rem) begin
            if (re) begin m_lp[c] = line_pos_i[c]; m_ln[c] = line_neg_i[c]; end
          end else if (te) begin
            m_lp[c] = txp; m_ln[c] = txn;
          end
        end
        if (ana) begin
          if (te) begin m_tp[c] = txp; m_tn[c] = txn; end
        end else if (re) begin
          if (single_rail_i) begin
            m_tp[c] = line_pos_i[c] | line_neg_i[c]; m_tn[c] = 0;
          end else begin
            m_tp[c] = line_pos_i[c]; m_tn[c] = line_neg_i[c];
          end
        end
        if (single_rail_i) m_tn[c] = 0;
        p_t[c] = tclk_i[c]; p_r[c] = rclk_i[c];
      end
      p_m = mclk_i;
    end
  end

  function automatic logic [N-1:0] pack(input bit a[N]);
    logic [N-1:0] v;
    for (int c = 0; c < N; c++) v[c] = a[c];
    return v;
  endfunction

  task automatic cmp(input string what, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (comparing && rst_ni && !done) begin
      cmp("line_pos", line_pos_o, pack(m_lp));
      cmp("line_neg", line_neg_o, pack(m_ln));
      cmp("term_pos", term_pos_o, pack(m_tp));
      cmp("term_neg", term_neg_o, pack(m_tn));
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
      term_pos_i = N'($urandom); term_neg_i = N'($urandom);
      line_pos_i = N'($urandom); line_neg_i = N'($urandom);
      if (tog_t) tclk_i = tclk_i ^ N'($urandom);
      if (tog_r) rclk_i = rclk_i ^ N'($urandom);
      if (tog_m && ($urandom % 2 == 0)) mclk_i = ~mclk_i;
    end
  endtask

  initial begin
    #12000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state and first cycle after release
    repeat (3) @(negedge clk);
    tag = "R1";
    cmp("line_pos", line_pos_o, '0); cmp("line_neg", line_neg_o, '0);
    cmp("term_pos", term_pos_o, '0); cmp("term_neg", term_neg_o, '0);
    #1 rst_ni = 1'b1;
    @(negedge clk);
    cmp("line_pos", line_pos_o, '0); cmp("term_pos", term_pos_o, '0);
    comparing = 1;

    // R2 / R3: both sampling polarities, no loopback
    for (int p = 0; p < 4; p++) begin
      tag = (p < 2) ? "R2" : "R3";
      tclk_rise_i = p[0]; rclk_rise_i = ~p[0];
      step(150);
    end

    // R4 / R5: analog loopback on each selector code, then disabled
    tag = "R5";
    lb_analog_i = 1;
    for (int s = 0; s < 8; s++) begin
      lb_en_ni = 0; lb_sel_i = 3'(s);
      step(80);
      tag = "R4"; lb_en_ni = 1; step(20); tag = "R5";
    end

    // R4 / R6: remote loopback on each selector code
    tag = "R6";
    lb_analog_i = 0;
    for (int s = 0; s < 8; s++) begin
      lb_en_ni = 0; lb_sel_i = 3'(s);
      step(80);
      tag = "R4"; lb_en_ni = 1; step(20); tag = "R6";
    end

    // R7: single-rail in normal and both loopback types
    tag = "R7";
    single_rail_i = 1;
    step(150);
    lb_en_ni = 0; lb_analog_i = 1; lb_sel_i = 3'd0; step(100);
    lb_analog_i = 0; lb_sel_i = 3'd4; step(100);
    lb_en_ni = 1; single_rail_i = 0; step(20);

    // R8: all-ones with random masks, including over remote loopback
    tag = "R8";
    tog_m = 1;
    for (int k = 0; k < 6; k++) begin
      all_ones_i = N'($urandom);
      lb_en_ni = k[0]; lb_analog_i = 0; lb_sel_i = 3'd0;
      step(120);
    end
    tog_m = 0; step(60);
    all_ones_i = '1; tog_m = 1; step(80);
    all_ones_i = '0; lb_en_ni = 1;

    // R9: data moves, clocks frozen
    tag = "R9";
    tog_t = 0; tog_r = 0; tog_m = 0;
    single_rail_i = 1; step(5); single_rail_i = 0; step(5);
    lb_en_ni = 0; lb_analog_i = 1; step(60);
    lb_analog_i = 0; all_ones_i = '1; step(60);

    @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule